// File: doc/BRIEF.md
# Banked ROM/RAM Memory Mapper

This block sits between a 16-bit CPU and its memories and turns each memory access into a chip-select decision. The possible targets are a fixed monitor ROM, one page of a paged ROM, a paged RAM window, or a 16K RAM area that is shared by every page. A single write-only configuration byte holds three things: a ROM page number, a RAM page number, and a map-mode flag. Software writes this byte through the page port strobe.

Two memory maps are available:

- **ROM map (mode flag clear).**
  - The bottom 8K always reaches the monitor ROM.
  - The next 8K shows one of eight ROM pages.
  - The 32K from 4000h to BFFFh is a RAM window. Its page comes from the RAM page field.
- **RAM map (mode flag set).** Every ROM is switched out, and the whole region below C000h is a 48K paged RAM window.

In both maps the top 16K is the common RAM. The RAM page number drives the extended bank bits that the memory array adds above the CPU address.

Top module: `bank_mapper`

## Requirements
- R1: Synchronous reset clears the configuration byte to 00h. The block then uses the ROM map with ROM page 0 and RAM page 0.
- R2: A clock edge with `io_wr` high loads `io_data` into the configuration byte, and the new value takes effect in the next cycle. The fields are: bit 7 is the map mode (1 = RAM map), bits 6:4 are the ROM page, and bits 3:0 are the RAM page.
- R3: In the ROM map, a request to 0000h–1FFFh asserts `rom_sel` and `rom_monitor`, with `rom_page` = 0.
- R4: In the ROM map, a request to 2000h–3FFFh asserts `rom_sel` with `rom_monitor` low and `rom_page` equal to the ROM page field.
- R5: In the ROM map, a request to 4000h–BFFFh asserts `ram_sel` with `ram_common` low and `ram_bank` equal to the RAM page field.
- R6: In either map, a request to C000h–FFFFh asserts `ram_sel` and `ram_common`, with `ram_bank` = 0.
- R7: In the RAM map, a request to 0000h–BFFFh asserts `ram_sel` with `ram_bank` equal to the RAM page field, and `rom_sel` stays low.
- R8: With `mem_req` low, every output is 0.
- R9: `rom_sel` and `ram_sel` are never high together.
- R10: While `io_wr` is low, changes on `io_data` leave the configuration and all outputs unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| mem_req | input | 1 | Memory request, active high |
| io_wr | input | 1 | Page port write strobe, active high |
| io_data | input | 8 | Page port write data |
| rom_sel | output | 1 | ROM select |
| rom_monitor | output | 1 | Fixed monitor ROM is the target |
| rom_page | output | 3 | Paged ROM number |
| ram_sel | output | 1 | RAM select |
| ram_common | output | 1 | Common top-16K RAM is the target |
| ram_bank | output | 4 | Extended RAM bank bits |

## Verification
The assertions check four properties on every cycle:
- the two selects never overlap;
- an idle bus drives every output to zero;
- the top 16K always lands in common RAM with bank zero, and the monitor ROM never carries a page number;
- a page port write shows up in the window bank one cycle later, while outputs hold steady when neither the address nor the configuration can change.

Some behaviour can only be shown by the bench's scenarios:
- that the ROM page reaches the paged ROM window;
- that the RAM map removes the ROM over the full 48K;
- that reset restores the ROM map;
- that a strobe-less data change is ignored.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int ROM_PG_W = 3;
    localparam int RAM_PG_W = 4;

    // Configuration byte: field order sets the bit positions (mode on top)
    typedef struct packed {
        logic                ram_mode;
        logic [ROM_PG_W-1:0] rom_pg;
        logic [RAM_PG_W-1:0] ram_pg;
    } page_cfg_t;

    typedef enum logic [2:0] {
        RGN_IDLE,
        RGN_MONITOR,
        RGN_ROM_WIN,
        RGN_RAM_WIN,
        RGN_COMMON
    } region_e;

    typedef struct packed {
        logic                rom_sel;
        logic                rom_monitor;
        logic [ROM_PG_W-1:0] rom_page;
        logic                ram_sel;
        logic                ram_common;
        logic [RAM_PG_W-1:0] ram_bank;
    } map_out_t;

    // quarter: address bits 15:14, eighth: bit 13
    function automatic region_e classify(input logic [1:0] quarter,
                                         input logic       eighth,
                                         input logic       ram_mode,
                                         input logic       req);
        if (!req)                return RGN_IDLE;
        if (quarter == 2'b11)    return RGN_COMMON;
        if (ram_mode)            return RGN_RAM_WIN;
        if (quarter != 2'b00)    return RGN_RAM_WIN;
        if (eighth)              return RGN_ROM_WIN;
        return RGN_MONITOR;
    endfunction

endpackage

// File: rtl/page_port.sv
module page_port
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output page_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= page_cfg_t'(wr_data);
    end

endmodule

// File: rtl/map_decode.sv
module map_decode
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              req,
    input  page_cfg_t         cfg,
    output map_out_t          sel
);

    region_e rgn;

    always_comb begin
        rgn = classify(addr[ADDR_W-1 -: 2], addr[ADDR_W-3], cfg.ram_mode, req);
        sel = '0;
        unique case (rgn)
            RGN_MONITOR: begin
                sel.rom_sel     = 1'b1;
                sel.rom_monitor = 1'b1;
            end
            RGN_ROM_WIN: begin
                sel.rom_sel  = 1'b1;
                sel.rom_page = cfg.rom_pg;
            end
            RGN_RAM_WIN: begin
                sel.ram_sel  = 1'b1;
                sel.ram_bank = cfg.ram_pg;
            end
            RGN_COMMON: begin
                sel.ram_sel    = 1'b1;
                sel.ram_common = 1'b1;
            end
            default: sel = '0;
        endcase
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                mem_req,
    input  logic                io_wr,
    input  logic [DATA_W-1:0]   io_data,
    output logic                rom_sel,
    output logic                rom_monitor,
    output logic [ROM_PG_W-1:0] rom_page,
    output logic                ram_sel,
    output logic                ram_common,
    output logic [RAM_PG_W-1:0] ram_bank
);

    page_cfg_t cfg;
    map_out_t  sel;

    page_port u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (io_wr),
        .wr_data (io_data),
        .cfg     (cfg)
    );

    map_decode u_dec (
        .addr (cpu_addr),
        .req  (mem_req),
        .cfg  (cfg),
        .sel  (sel)
    );

    assign rom_sel     = sel.rom_sel;
    assign rom_monitor = sel.rom_monitor;
    assign rom_page    = sel.rom_page;
    assign ram_sel     = sel.ram_sel;
    assign ram_common  = sel.ram_common;
    assign ram_bank    = sel.ram_bank;

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import mmap_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic                mem_req,
    input logic                io_wr,
    input logic [DATA_W-1:0]   io_data,
    input logic                rom_sel,
    input logic                rom_monitor,
    input logic [ROM_PG_W-1:0] rom_page,
    input logic                ram_sel,
    input logic                ram_common,
    input logic [RAM_PG_W-1:0] ram_bank
);

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && ram_sel)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (!rom_sel && !ram_sel && !rom_monitor && !ram_common
                      && rom_page == '0 && ram_bank == '0)); // R8

    AST_TOP_COMMON: assert property (@(posedge clk) disable iff (rst)
        (mem_req && cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2])
        |-> (ram_sel && ram_common && ram_bank == '0)); // R6

    AST_MONITOR_UNPAGED: assert property (@(posedge clk) disable iff (rst)
        rom_monitor |-> (rom_sel && rom_page == '0)); // R3

    AST_WRITE_TO_BANK: assert property (@(posedge clk) disable iff (rst)
        ($past(io_wr) && mem_req && cpu_addr[ADDR_W-1:ADDR_W-2] inside {2'b01, 2'b10})
        |-> (ram_bank == $past(io_data[RAM_PG_W-1:0]))); // R2

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!$past(io_wr) && $stable(cpu_addr) && $stable(mem_req))
        |-> ($stable(rom_sel) && $stable(ram_sel) && $stable(rom_page)
             && $stable(ram_bank))); // R10

endmodule

bind bank_mapper bank_mapper_chk u_chk (.*);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        mem_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_data = '0;
    logic        rom_sel, rom_monitor, ram_sel, ram_common;
    logic [2:0]  rom_page;
    logic [3:0]  ram_bank;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    logic [7:0] m_cfg;

    always #5 clk = ~clk;

    bank_mapper uut (.*);

    // behavioural configuration register
    always @(posedge clk) begin
        if (rst)        m_cfg <= 8'h00;
        else if (io_wr) m_cfg <= io_data;
    end

    task automatic apply(input logic [15:0] a, input logic rq, input logic w,
                         input logic [7:0] d, input string tag);
        int e_rs, e_mon, e_rp, e_ms, e_cm, e_bk;
        string t;
        int addr;
        @(negedge clk);
        cpu_addr = a; mem_req = rq; io_wr = w; io_data = d;
        #1;
        addr = int'(a);
        e_rs = 0; e_mon = 0; e_rp = 0; e_ms = 0; e_cm = 0; e_bk = 0;
        if (!rq)                 begin t = "R8"; end
        else if (addr >= 'hC000) begin t = "R6"; e_ms = 1; e_cm = 1; end
        else if (m_cfg[7])       begin t = "R7"; e_ms = 1; e_bk = int'(m_cfg[3:0]); end
        else if (addr >= 'h4000) begin t = "R5"; e_ms = 1; e_bk = int'(m_cfg[3:0]); end
        else if (addr >= 'h2000) begin t = "R4"; e_rs = 1; e_rp = int'(m_cfg[6:4]); end
        else                     begin t = "R3"; e_rs = 1; e_mon = 1; end
        if (tag != "") t = tag;
        vectors++;
        if (int'(rom_sel) != e_rs || int'(rom_monitor) != e_mon || int'(rom_page) != e_rp ||
            int'(ram_sel) != e_ms || int'(ram_common) != e_cm || int'(ram_bank) != e_bk) begin
            errors++;
            $display("FAIL %s addr=%h got rs=%0d mon=%0d rp=%0d ms=%0d cm=%0d bk=%0d exp rs=%0d mon=%0d rp=%0d ms=%0d cm=%0d bk=%0d",
                     t, a, rom_sel, rom_monitor, rom_page, ram_sel, ram_common, ram_bank,
                     e_rs, e_mon, e_rp, e_ms, e_cm, e_bk);
        end
        vectors++;
        if (rom_sel && ram_sel) begin // R9
            errors++;
            $display("FAIL R9 both selects high: got 1/1 expected not both");
        end
    endtask

    initial begin
        // R1: reset state gives the ROM map with page 0
        apply(16'h0000, 1, 0, 8'h00, "R1");
        apply(16'h2000, 1, 0, 8'h00, "R1");
        @(negedge clk); rst = 1'b0;
        apply(16'h1FFF, 1, 0, 8'h00, "R1");
        apply(16'h4000, 1, 0, 8'h00, "R1");
        // R2: write mode0, ROM page 5, RAM page A
        apply(16'h0000, 0, 1, 8'h5A, "R2");
        apply(16'h2345, 1, 0, 8'h00, "R2");
        apply(16'h3FFF, 1, 0, 8'h00, "R4");
        apply(16'h7FFF, 1, 0, 8'h00, "R5");
        apply(16'hBFFF, 1, 0, 8'h00, "R5");
        apply(16'h0100, 1, 0, 8'h00, "R3");
        apply(16'hC000, 1, 0, 8'h00, "R6");
        apply(16'h5000, 0, 0, 8'h00, "R8");
        // RAM map: mode1, ROM page 1, RAM page 3
        apply(16'h1234, 1, 1, 8'h93, "R2");
        apply(16'h0000, 1, 0, 8'h00, "R7");
        apply(16'h3FFF, 1, 0, 8'h00, "R7");
        apply(16'hBFFF, 1, 0, 8'h00, "R7");
        apply(16'hFFFF, 1, 0, 8'h00, "R6");
        // R10: data without strobe
        apply(16'h8000, 1, 0, 8'h0F, "R10");
        apply(16'h8000, 1, 0, 8'hFF, "R10");
        apply(16'h2000, 1, 0, 8'h00, "R10");
        // back to ROM map
        apply(16'h0000, 0, 1, 8'h70, "R2");
        apply(16'h2000, 1, 0, 8'h00, "R4");
        apply(16'h1000, 1, 0, 8'h00, "R3");
        for (int i = 0; i < 3000; i++)
            apply(16'($urandom), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 7) == 0), 8'($urandom), "");
        // R1: reset mid-run returns to ROM map
        @(negedge clk); rst = 1'b1;
        apply(16'h0000, 0, 0, 8'h00, "R1");
        @(negedge clk); rst = 1'b0;
        apply(16'h0800, 1, 0, 8'h00, "R1");
        apply(16'h6000, 1, 0, 8'h00, "R1");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule